// File: doc/BRIEF.md
# Deep-Standby Entry and Wake Controller

This block sequences a microcontroller core into and out of its deepest standby state. When the CPU issues a stop request while it runs from the main clock, the controller turns off the main oscillator and gates the CPU clock. It also forces the external expansion bus into a defined idle condition. The subsystem clock is not touched. Any interrupt that is requested and not masked wakes the block. It then turns the oscillator back on and counts a stabilization wait before it gives the clock back to the CPU.

The wait length comes from a 3-bit select input, which is captured when the wait begins. A request that arrives while an unmasked interrupt is already pending skips the stopped state and goes straight into the wait. This gives the same result as a short halt. A two-bit status output reports the current phase. A one-cycle pulse marks the return to normal operation.

Top module: `stopctl_top`

## Requirements
- R1: A stop request is accepted only in RUN with `clk_sel_sub`=0 and `ext_clk_sel`=0. Otherwise it is ignored: the status stays RUN and both clock enables stay 1.
- R2: While the status is STOP (code 2'b01), `main_osc_en`=0 and `cpu_clk_en`=0.
- R3: In STOP, the block moves to STAB (code 2'b10) on the clock edge after any bit of `irq_req` is 1 with the same bit of `irq_mask` at 0. A mask bit of 1 keeps that request from waking the block.
- R4: If a wake condition is present on the edge that accepts a stop request, the status goes directly from RUN to STAB and never shows STOP.
- R5: STAB lasts exactly 2^(E-STAB_SCALE) cycles. E is 12, 14, 15, 16 or 17 for `stab_sel` codes 0 to 4, and the code is captured on entry to STAB. During STAB, `main_osc_en`=1 and `cpu_clk_en`=0.
- R6: `stab_sel` codes 5, 6 and 7 select the longest wait (E=17).
- R7: Whenever the status is not RUN, the bus pads are forced as follows: `pad_ad_oe`=0, `pad_ahi_oe`=0, `pad_astb`=0, `pad_rd_n`=1 and `pad_wr_n`=1. In RUN, all of these pads pass the CPU values through unchanged.
- R8: `port_we` follows `cpu_port_we` in RUN and is held at 0 in every other state, so the port latches keep their values.
- R9: `wake_done` is 1 for exactly one cycle, the first RUN cycle after STAB. The status codes are RUN=2'b00, STOP=2'b01 and STAB=2'b10.
- R10: Reset gives status RUN, both clock enables at 1, pads in pass-through and `wake_done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop request from the CPU |
| clk_sel_sub | input | 1 | 1 = CPU runs from the subsystem clock |
| ext_clk_sel | input | 1 | 1 = main clock is supplied externally |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_mask | input | IRQ_N | Interrupt mask flags (1 = masked) |
| stab_sel | input | 3 | Stabilization wait select |
| cpu_ad_out | input | AD_W | CPU drive for the multiplexed address/data lines |
| cpu_ad_oe | input | 1 | CPU output enable for the address/data lines |
| cpu_ahi_out | input | AHI_W | CPU drive for the upper address lines |
| cpu_ahi_oe | input | 1 | CPU output enable for the upper address lines |
| cpu_astb | input | 1 | CPU address strobe |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_port_we | input | 1 | CPU port latch write enable |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| pad_ad_out | output | AD_W | Address/data pad data |
| pad_ad_oe | output | 1 | Address/data pad output enable |
| pad_ahi_out | output | AHI_W | Upper address pad data |
| pad_ahi_oe | output | 1 | Upper address pad output enable |
| pad_astb | output | 1 | Address strobe pad |
| pad_rd_n | output | 1 | Read strobe pad |
| pad_wr_n | output | 1 | Write strobe pad |
| port_we | output | 1 | Gated port latch write enable |
| status | output | 2 | Current phase: RUN, STOP or STAB |
| wake_done | output | 1 | One-cycle pulse on the return to RUN |

## Verification
The bench builds the block with `STAB_SCALE`=8. This shrinks the five waits to 16, 64, 128, 256 and 512 cycles, so every select code, including the unused ones, can be run to its last cycle and counted exactly. `IRQ_N`, `AD_W` and `AHI_W` keep their defaults of 8. With these values, the bench can exercise a masked request that must not wake the block, and a pending request that must bypass STOP.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_STOP = 2'b01,
    ST_STAB = 2'b10
  } stop_state_e;

  localparam int STAB_EXP_MAX = 17;

  function automatic int stab_exp(input logic [2:0] code);
    case (code)
      3'd0:    stab_exp = 12;
      3'd1:    stab_exp = 14;
      3'd2:    stab_exp = 15;
      3'd3:    stab_exp = 16;
      default: stab_exp = STAB_EXP_MAX;
    endcase
  endfunction

endpackage

// File: rtl/stopctl_seq.sv
module stopctl_seq
  import stopctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_req,
  input  logic        clk_sel_sub,
  input  logic        ext_clk_sel,
  input  logic        wake,
  input  logic        stab_last,
  output stop_state_e state,
  output logic        enter_stab,
  output logic        wake_done
);

  stop_state_e state_nx;
  logic        done_nx;
  logic        req_ok;

  assign req_ok = stop_req & ~clk_sel_sub & ~ext_clk_sel;

  always_comb begin
    state_nx   = state;
    done_nx    = 1'b0;
    enter_stab = 1'b0;
    case (state)
      ST_RUN: begin
        if (req_ok) begin
          if (wake) begin
            state_nx   = ST_STAB;
            enter_stab = 1'b1;
          end else begin
            state_nx = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (wake) begin
          state_nx   = ST_STAB;
          enter_stab = 1'b1;
        end
      end
      ST_STAB: begin
        if (stab_last) begin
          state_nx = ST_RUN;
          done_nx  = 1'b1;
        end
      end
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      wake_done <= 1'b0;
    end else begin
      state     <= state_nx;
      wake_done <= done_nx;
    end
  end

endmodule

// File: rtl/stopctl_stab_timer.sv
module stopctl_stab_timer
  import stopctl_pkg::*;
#(
  parameter int STAB_SCALE = 0,
  localparam int CNT_W = STAB_EXP_MAX - STAB_SCALE + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] sel,
  input  logic       run,
  output logic       last
);

  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             cnt_en;

  always_comb begin
    limit = (CNT_W'(1) << (stab_exp(sel_q) - STAB_SCALE)) - CNT_W'(1);
  end

  assign cnt_en = run;
  assign last   = run & (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 3'd0;
    end else if (load) begin
      sel_q <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/stopctl_pad_guard.sv
module stopctl_pad_guard #(
  parameter int AD_W  = 8,
  parameter int AHI_W = 8
) (
  input  logic             idle,
  input  logic [AD_W-1:0]  cpu_ad_out,
  input  logic             cpu_ad_oe,
  input  logic [AHI_W-1:0] cpu_ahi_out,
  input  logic             cpu_ahi_oe,
  input  logic             cpu_astb,
  input  logic             cpu_rd_n,
  input  logic             cpu_wr_n,
  input  logic             cpu_port_we,
  output logic [AD_W-1:0]  pad_ad_out,
  output logic             pad_ad_oe,
  output logic [AHI_W-1:0] pad_ahi_out,
  output logic             pad_ahi_oe,
  output logic             pad_astb,
  output logic             pad_rd_n,
  output logic             pad_wr_n,
  output logic             port_we
);

  always_comb begin
    pad_ad_out  = cpu_ad_out;
    pad_ahi_out = cpu_ahi_out;
    if (idle) begin
      pad_ad_oe  = 1'b0;
      pad_ahi_oe = 1'b0;
      pad_astb   = 1'b0;
      pad_rd_n   = 1'b1;
      pad_wr_n   = 1'b1;
      port_we    = 1'b0;
    end else begin
      pad_ad_oe  = cpu_ad_oe;
      pad_ahi_oe = cpu_ahi_oe;
      pad_astb   = cpu_astb;
      pad_rd_n   = cpu_rd_n;
      pad_wr_n   = cpu_wr_n;
      port_we    = cpu_port_we;
    end
  end

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
  import stopctl_pkg::*;
#(
  parameter int IRQ_N      = 8,
  parameter int AD_W       = 8,
  parameter int AHI_W      = 8,
  parameter int STAB_SCALE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             clk_sel_sub,
  input  logic             ext_clk_sel,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic [IRQ_N-1:0] irq_mask,
  input  logic [2:0]       stab_sel,
  input  logic [AD_W-1:0]  cpu_ad_out,
  input  logic             cpu_ad_oe,
  input  logic [AHI_W-1:0] cpu_ahi_out,
  input  logic             cpu_ahi_oe,
  input  logic             cpu_astb,
  input  logic             cpu_rd_n,
  input  logic             cpu_wr_n,
  input  logic             cpu_port_we,
  output logic             main_osc_en,
  output logic             cpu_clk_en,
  output logic [AD_W-1:0]  pad_ad_out,
  output logic             pad_ad_oe,
  output logic [AHI_W-1:0] pad_ahi_out,
  output logic             pad_ahi_oe,
  output logic             pad_astb,
  output logic             pad_rd_n,
  output logic             pad_wr_n,
  output logic             port_we,
  output logic [1:0]       status,
  output logic             wake_done
);

  logic        rst_meta_n;
  logic        rst_sync_n;
  logic        wake;
  logic        enter_stab;
  logic        stab_last;
  stop_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wake = |(irq_req & ~irq_mask);

  stopctl_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stop_req   (stop_req),
    .clk_sel_sub(clk_sel_sub),
    .ext_clk_sel(ext_clk_sel),
    .wake       (wake),
    .stab_last  (stab_last),
    .state      (state),
    .enter_stab (enter_stab),
    .wake_done  (wake_done)
  );

  stopctl_stab_timer #(.STAB_SCALE(STAB_SCALE)) tmr_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .load (enter_stab),
    .sel  (stab_sel),
    .run  (state == ST_STAB),
    .last (stab_last)
  );

  stopctl_pad_guard #(.AD_W(AD_W), .AHI_W(AHI_W)) pad_i (
    .idle       (state != ST_RUN),
    .cpu_ad_out (cpu_ad_out),
    .cpu_ad_oe  (cpu_ad_oe),
    .cpu_ahi_out(cpu_ahi_out),
    .cpu_ahi_oe (cpu_ahi_oe),
    .cpu_astb   (cpu_astb),
    .cpu_rd_n   (cpu_rd_n),
    .cpu_wr_n   (cpu_wr_n),
    .cpu_port_we(cpu_port_we),
    .pad_ad_out (pad_ad_out),
    .pad_ad_oe  (pad_ad_oe),
    .pad_ahi_out(pad_ahi_out),
    .pad_ahi_oe (pad_ahi_oe),
    .pad_astb   (pad_astb),
    .pad_rd_n   (pad_rd_n),
    .pad_wr_n   (pad_wr_n),
    .port_we    (port_we)
  );

  assign main_osc_en = (state != ST_STOP);
  assign cpu_clk_en  = (state == ST_RUN);
  assign status      = state;

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk #(
  parameter int IRQ_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             clk_sel_sub,
  input logic             ext_clk_sel,
  input logic [IRQ_N-1:0] irq_req,
  input logic [IRQ_N-1:0] irq_mask,
  input logic             main_osc_en,
  input logic             cpu_clk_en,
  input logic             pad_ad_oe,
  input logic             pad_ahi_oe,
  input logic             pad_astb,
  input logic             pad_rd_n,
  input logic             pad_wr_n,
  input logic             port_we,
  input logic [1:0]       status,
  input logic             wake_done
);

  logic wk;
  assign wk = |(irq_req & ~irq_mask);

  assert_ignore_sub_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && stop_req && (clk_sel_sub || ext_clk_sel)) |=> status == 2'b00);

  assert_stop_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> (!main_osc_en && !cpu_clk_en));

  assert_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && wk) |=> status == 2'b10);

  assert_stay_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && !wk) |=> status == 2'b01);

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && stop_req && !clk_sel_sub && !ext_clk_sel && wk) |=> status == 2'b10);

  assert_stab_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b10) |-> (main_osc_en && !cpu_clk_en));

  assert_pads_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00) |-> (!pad_ad_oe && !pad_ahi_oe && !pad_astb && pad_rd_n && pad_wr_n));

  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00) |-> !port_we);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (status == 2'b00 && $past(status) == 2'b10));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

endmodule

bind stopctl_top stopctl_chk #(.IRQ_N(IRQ_N)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .stop_req   (stop_req),
  .clk_sel_sub(clk_sel_sub),
  .ext_clk_sel(ext_clk_sel),
  .irq_req    (irq_req),
  .irq_mask   (irq_mask),
  .main_osc_en(main_osc_en),
  .cpu_clk_en (cpu_clk_en),
  .pad_ad_oe  (pad_ad_oe),
  .pad_ahi_oe (pad_ahi_oe),
  .pad_astb   (pad_astb),
  .pad_rd_n   (pad_rd_n),
  .pad_wr_n   (pad_wr_n),
  .port_we    (port_we),
  .status     (status),
  .wake_done  (wake_done)
);

// File: tb/stopctl_tb_top.sv
module stopctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SCALE      = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req, clk_sel_sub, ext_clk_sel;
  logic [7:0] irq_req, irq_mask;
  logic [2:0] stab_sel;
  logic [7:0] cpu_ad_out, cpu_ahi_out;
  logic       cpu_ad_oe, cpu_ahi_oe, cpu_astb, cpu_rd_n, cpu_wr_n, cpu_port_we;
  logic       main_osc_en, cpu_clk_en;
  logic [7:0] pad_ad_out, pad_ahi_out;
  logic       pad_ad_oe, pad_ahi_oe, pad_astb, pad_rd_n, pad_wr_n, port_we;
  logic [1:0] status;
  logic       wake_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stopctl_top #(.IRQ_N(8), .AD_W(8), .AHI_W(8), .STAB_SCALE(SCALE)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .clk_sel_sub(clk_sel_sub),
    .ext_clk_sel(ext_clk_sel), .irq_req(irq_req), .irq_mask(irq_mask),
    .stab_sel(stab_sel), .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe),
    .cpu_ahi_out(cpu_ahi_out), .cpu_ahi_oe(cpu_ahi_oe), .cpu_astb(cpu_astb),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_port_we(cpu_port_we),
    .main_osc_en(main_osc_en), .cpu_clk_en(cpu_clk_en), .pad_ad_out(pad_ad_out),
    .pad_ad_oe(pad_ad_oe), .pad_ahi_out(pad_ahi_out), .pad_ahi_oe(pad_ahi_oe),
    .pad_astb(pad_astb), .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n),
    .port_we(port_we), .status(status), .wake_done(wake_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // pad bundle: {ad_oe, ahi_oe, astb, rd_n, wr_n, port_we}
  function automatic logic [5:0] pads();
    return {pad_ad_oe, pad_ahi_oe, pad_astb, pad_rd_n, pad_wr_n, port_we};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; stop_req = 0; clk_sel_sub = 0; ext_clk_sel = 0;
    irq_req = '0; irq_mask = '1; stab_sel = 3'd0;
    cpu_ad_out = 8'hA5; cpu_ahi_out = 8'h3C; cpu_ad_oe = 1; cpu_ahi_oe = 1;
    cpu_astb = 1; cpu_rd_n = 0; cpu_wr_n = 0; cpu_port_we = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 status", status, 2'b00);
    check("R10 clocks", {main_osc_en, cpu_clk_en}, 2'b11);
    check("R10 done", wake_done, 1'b0);
    check("R7 run passthru", {pads(), pad_ad_out, pad_ahi_out}, {6'b111001, 8'hA5, 8'h3C});
  endtask

  task automatic t_ignored(input bit sub, input bit ext);
    clk_sel_sub = sub; ext_clk_sel = ext; stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    check("R1 ignored status", status, 2'b00);
    check("R1 ignored clocks", {main_osc_en, cpu_clk_en}, 2'b11);
    @(negedge clk);
    check("R1 ignored later", status, 2'b00);
    clk_sel_sub = 0; ext_clk_sel = 0;
  endtask

  // at entry: first STAB cycle already sampled; len = expected STAB cycles
  task automatic run_stab(input string tag, input int len);
    check({tag, " stab clocks"}, {main_osc_en, cpu_clk_en}, 2'b10);
    check({tag, " stab pads"}, pads(), 6'b000110);
    repeat (len - 1) @(negedge clk);
    check({tag, " last stab cycle"}, status, 2'b10);
    @(negedge clk);
    check({tag, " back to run"}, status, 2'b00);
    check("R9 done pulse", wake_done, 1'b1);
    check("R9 clocks on", {main_osc_en, cpu_clk_en}, 2'b11);
    @(negedge clk);
    check("R9 done single", wake_done, 1'b0);
  endtask

  task automatic t_stop_wake(input logic [2:0] sel, input int len, input string tag);
    stab_sel = sel; irq_req = 8'h00; irq_mask = 8'hFF; stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    check("R2 stop status", status, 2'b01);
    check("R2 stop clocks", {main_osc_en, cpu_clk_en}, 2'b00);
    check("R7 stop pads", pads(), 6'b000110);
    check("R8 port hold", port_we, 1'b0);
    irq_req = 8'h10; irq_mask = 8'hFF;
    repeat (3) @(negedge clk);
    check("R3 masked no wake", status, 2'b01);
    irq_mask = 8'hEF;
    @(negedge clk);
    irq_req = 8'h00; irq_mask = 8'hFF;
    stab_sel = ~sel;
    check("R3 wake to stab", status, 2'b10);
    run_stab(tag, len);
  endtask

  task automatic t_pending(input logic [2:0] sel, input int len);
    stab_sel = sel; irq_req = 8'h01; irq_mask = 8'hFE; stop_req = 1;
    @(negedge clk);
    stop_req = 0; irq_req = 8'h00; irq_mask = 8'hFF;
    check("R4 direct stab", status, 2'b10);
    run_stab("R4", len);
  endtask

  initial begin
    t_reset();
    t_ignored(1'b1, 1'b0);
    t_ignored(1'b0, 1'b1);
    t_stop_wake(3'd0, 16, "R5 sel0");
    t_stop_wake(3'd1, 64, "R5 sel1");
    t_pending(3'd2, 128);
    t_stop_wake(3'd3, 256, "R5 sel3");
    t_pending(3'd4, 512);
    t_stop_wake(3'd5, 512, "R6 sel5");
    t_stop_wake(3'd7, 512, "R6 sel7");
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule